// File: doc/BRIEF.md
# Slave Multiply-Accumulate Processing Array

This block is the worker side of a blocked matrix multiplier. It holds a row of processing elements (four by default). Each element owns one entry of the current C block and keeps a running sum in a local accumulator. A controlling master puts one packed word of A-column operands and one B-row element on the block's inputs. It then pulses a data acknowledge. The slave copies both operands into its own registers in the next cycle. In the cycle after that, every element adds the product of its own A lane and the shared B element into its accumulator.

If the master's done input is low at the end of the compute cycle, the slave goes back to waiting and raises its data request again. If done is high, the slave enters an unload phase. The accumulators are presented one per cycle in element order through a select-or-zero output stage. The accumulators are cleared at the end of the last unload cycle, so the next block starts from zero. An active-high reset of at least one clock is applied before each new operation.

Top module: `mac_slave_array`

## Requirements
- R1: After reset the slave is waiting: `data_req` is 1, `res_valid` is 0, `res_data` is 0, and all accumulators hold zero.
- R2: While waiting with `data_ack` low, the slave stays in the waiting state with `data_req` high. Changes on the operand inputs have no effect on any accumulator.
- R3: The operands are captured from `fifo_a_word` and `fifo_b_elem` in the cycle after the one in which `data_ack` was seen high. Values driven on those inputs in any other cycle are not used.
- R4: Processing element i multiplies bits [8i+7:8i] of the A word by the shared B element, both unsigned. It adds the 16-bit product into its own accumulator.
- R5: `main_done` is sampled in the compute cycle. If it is 0, the slave returns to waiting, and `data_req` is high again three cycles after `data_ack` was sampled. If it is 1, the unload phase starts in the next cycle.
- R6: Unloading lasts exactly four cycles. `res_valid` is 1 throughout, and `res_idx` goes 0, 1, 2, 3. `res_data` carries the accumulator of element `res_idx`.
- R7: `data_req` is 0 in every cycle of the unload phase, including the fourth. It is 1 again in the cycle after the phase ends.
- R8: Whenever `res_valid` is 0, `res_data` is 0.
- R9: The accumulators are cleared at the end of the fourth unload cycle. Results of the next block do not include earlier sums.
- R10: Each accumulator is 20 bits wide. Eight steps with both operands at 255 give 520200 in every element, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_ack | input | 1 | Master signals that operands follow in the next cycle |
| main_done | input | 1 | Master signals the last step of the block, sampled in the compute cycle |
| fifo_a_word | input | 32 | Packed A-column operands, lane i in bits [8i+7:8i] |
| fifo_b_elem | input | 8 | B-row element shared by every element |
| data_req | output | 1 | High while the slave waits for operands |
| res_valid | output | 1 | High during the four unload cycles |
| res_idx | output | 2 | Index of the element being presented |
| res_data | output | 20 | Selected accumulator during unload, zero otherwise |

## Verification
The last multiply-accumulate and the decision to unload fall in the same compute cycle. The first value presented must therefore already include the final product. The bench raises `main_done` together with the final operands and checks that the first unload beat equals the full sum and not the sum without the last step. The clear and the fourth unload beat also share a cycle. The bench checks that the fourth beat still shows the full element-3 sum, and that a following one-step block returns only its own product.

// File: rtl/mac_slave_pkg.sv
package mac_slave_pkg;
   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_LOAD = 2'd1,
      ST_CALC = 2'd2,
      ST_UNLD = 2'd3
   } slv_state_t;
endpackage

// File: rtl/mac_slave_fsm.sv
module mac_slave_fsm
   import mac_slave_pkg::*;
#(
   parameter int LANES = 4,
   localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ack_in,
   input  logic            done_in,
   output logic            ld_en,
   output logic            mac_en,
   output logic            acc_clr,
   output logic            unld,
   output logic [IDXW-1:0] sel,
   output logic            req
);
   localparam logic [IDXW-1:0] LAST = IDXW'(LANES - 1);

   slv_state_t state_q, state_d;
   logic [IDXW-1:0] sel_q, sel_d;

   always_comb begin
      state_d = state_q;
      sel_d   = sel_q;
      unique case (state_q)
         ST_WAIT: if (ack_in) state_d = ST_LOAD;
         ST_LOAD: state_d = ST_CALC;
         ST_CALC: begin
            sel_d   = '0;
            state_d = done_in ? ST_UNLD : ST_WAIT;
         end
         ST_UNLD: begin
            if (sel_q == LAST) begin
               state_d = ST_WAIT;
               sel_d   = '0;
            end else begin
               sel_d = sel_q + IDXW'(1);
            end
         end
         default: state_d = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_WAIT;
         sel_q   <= '0;
      end else begin
         state_q <= state_d;
         sel_q   <= sel_d;
      end
   end

   assign ld_en   = (state_q == ST_LOAD);
   assign mac_en  = (state_q == ST_CALC);
   assign unld    = (state_q == ST_UNLD);
   assign acc_clr = unld && (sel_q == LAST);
   assign sel     = sel_q;
   assign req     = (state_q == ST_WAIT);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (req && !ack_in) |=> req);
   // R5
   done_low_chk: assert property (@(posedge clk) disable iff (rst)
      (mac_en && !done_in) |=> (req && !unld));
   // R5
   done_high_chk: assert property (@(posedge clk) disable iff (rst)
      (mac_en && done_in) |=> (unld && sel == '0));
   // R6
   unload_order_chk: assert property (@(posedge clk) disable iff (rst)
      (unld && sel != LAST) |=> (unld && sel == $past(sel) + IDXW'(1)));
   // R7
   unload_end_chk: assert property (@(posedge clk) disable iff (rst)
      (unld && sel == LAST) |=> (req && !unld));
endmodule

// File: rtl/mac_pe.sv
module mac_pe #(
   parameter int OPW  = 8,
   parameter int ACCW = 20,
   localparam int PRODW = 2 * OPW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ld_en,
   input  logic            mac_en,
   input  logic            acc_clr,
   input  logic [OPW-1:0]  a_in,
   input  logic [OPW-1:0]  b_in,
   output logic [ACCW-1:0] acc_out
);
   logic [OPW-1:0]   a_q, b_q;
   logic [PRODW-1:0] prod;
   logic [ACCW-1:0]  acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else if (ld_en) begin
         a_q <= a_in;
         b_q <= b_in;
      end
   end

   assign prod = PRODW'(a_q) * PRODW'(b_q);

   always_ff @(posedge clk) begin
      if (rst || acc_clr) acc_q <= '0;
      else if (mac_en)    acc_q <= acc_q + ACCW'(prod);
   end

   assign acc_out = acc_q;

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      mac_en |=> (acc_out >= $past(acc_out)));
   // R9
   acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
      acc_clr |=> (acc_out == '0));
   // R2
   acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mac_en && !acc_clr) |=> $stable(acc_out));
endmodule

// File: rtl/mac_result_mux.sv
module mac_result_mux #(
   parameter int LANES = 4,
   parameter int ACCW  = 20,
   localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES*ACCW-1:0] acc_flat,
   input  logic [IDXW-1:0]       sel,
   input  logic                  unld,
   output logic [ACCW-1:0]       res
);
   logic [ACCW-1:0] picked;

   always_comb begin
      picked = '0;
      for (int i = 0; i < LANES; i++)
         if (sel == IDXW'(i)) picked = acc_flat[i*ACCW +: ACCW];
   end

   assign res = unld ? picked : '0;
endmodule

// File: rtl/mac_slave_array.sv
module mac_slave_array #(
   parameter int LANES = 4,
   parameter int OPW   = 8,
   parameter int ACCW  = 20,
   localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 data_ack,
   input  logic                 main_done,
   input  logic [LANES*OPW-1:0] fifo_a_word,
   input  logic [OPW-1:0]       fifo_b_elem,
   output logic                 data_req,
   output logic                 res_valid,
   output logic [IDXW-1:0]      res_idx,
   output logic [ACCW-1:0]      res_data
);
   generate
      if (ACCW < 2 * OPW) begin : g_bad_accw
         $error("mac_slave_array: ACCW must hold one full product");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("mac_slave_array: LANES must be at least 1");
      end
   endgenerate

   logic ld_en, mac_en, acc_clr, unld;
   logic [IDXW-1:0] sel;
   logic [LANES*ACCW-1:0] acc_flat;

   mac_slave_fsm #(.LANES(LANES)) u_fsm (
      .clk(clk), .rst(rst), .ack_in(data_ack), .done_in(main_done),
      .ld_en(ld_en), .mac_en(mac_en), .acc_clr(acc_clr), .unld(unld),
      .sel(sel), .req(data_req)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_pe
         mac_pe #(.OPW(OPW), .ACCW(ACCW)) u_pe (
            .clk(clk), .rst(rst), .ld_en(ld_en), .mac_en(mac_en),
            .acc_clr(acc_clr),
            .a_in(fifo_a_word[i*OPW +: OPW]),
            .b_in(fifo_b_elem),
            .acc_out(acc_flat[i*ACCW +: ACCW])
         );
      end
   endgenerate

   mac_result_mux #(.LANES(LANES), .ACCW(ACCW)) u_mux (
      .acc_flat(acc_flat), .sel(sel), .unld(unld), .res(res_data)
   );

   assign res_valid = unld;
   assign res_idx   = sel;

   // R7
   req_unload_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> !data_req);
   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> (res_data == '0));
endmodule

// File: tb/mac_slave_array_test.sv
module mac_slave_array_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        data_ack = 1'b0;
   logic        main_done = 1'b0;
   logic [31:0] fifo_a_word = '0;
   logic [7:0]  fifo_b_elem = '0;
   logic        data_req, res_valid;
   logic [1:0]  res_idx;
   logic [19:0] res_data;

   int checks = 0;
   int fails  = 0;
   int expv [4];
   bit finished = 1'b0;

   always #2 clk = ~clk;

   mac_slave_array uut (
      .clk(clk), .rst(rst), .data_ack(data_ack), .main_done(main_done),
      .fifo_a_word(fifo_a_word), .fifo_b_elem(fifo_b_elem),
      .data_req(data_req), .res_valid(res_valid), .res_idx(res_idx),
      .res_data(res_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; data_ack = 1'b0; main_done = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      foreach (expv[i]) expv[i] = 0;
   endtask

   // one operand step; done applies to the compute cycle
   task automatic step(input logic [31:0] a, input logic [7:0] b, input bit dn);
      @(negedge clk);
      data_ack = 1'b1;
      fifo_a_word = 32'hDEAD_BEEF; fifo_b_elem = 8'hEE;
      @(negedge clk);                       // LOAD cycle
      data_ack = 1'b0;
      fifo_a_word = a; fifo_b_elem = b; main_done = dn;
      @(negedge clk);                       // CALC cycle
      fifo_a_word = 32'h1357_9BDF; fifo_b_elem = 8'h77;  // R3 not captured
      chk(!data_req, "R3 req low in compute", data_req, 0);
      for (int i = 0; i < 4; i++) expv[i] += int'(a[i*8 +: 8]) * int'(b);
      @(negedge clk);
      main_done = 1'b0;
      if (!dn) chk(data_req && !res_valid, "R5 back to waiting", data_req, 1);
   endtask

   // called on the first unload negedge
   task automatic check_unload(input string tag);
      for (int i = 0; i < 4; i++) begin
         chk(res_valid === 1'b1, {tag, " R6 valid"}, res_valid, 1);
         chk(res_idx === 2'(i), {tag, " R6 index"}, res_idx, i);
         chk(res_data === 20'(expv[i]), {tag, " R4 result"}, res_data, expv[i]);
         chk(data_req === 1'b0, {tag, " R7 req low in unload"}, data_req, 0);
         @(negedge clk);
      end
      chk(data_req === 1'b1 && res_valid === 1'b0, {tag, " R7 req back"}, data_req, 1);
      chk(res_data === 20'd0, {tag, " R8 zero when idle"}, res_data, 0);
      foreach (expv[i]) expv[i] = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(data_req === 1'b1, "R1 req after reset", data_req, 1);
      chk(res_valid === 1'b0, "R1 valid after reset", res_valid, 0);
      chk(res_data === 20'd0, "R1 data after reset", res_data, 0);
      step(32'h0, 8'h0, 1'b1);
      check_unload("R1 zero accumulators");
   endtask

   task automatic t_idle_ignore();
      do_reset();
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         fifo_a_word = 32'h0101_0101 * (k + 3); fifo_b_elem = 8'(k + 9);
         chk(data_req === 1'b1, "R2 stays waiting", data_req, 1);
         chk(res_data === 20'd0, "R8 idle output", res_data, 0);
      end
      step(32'h0403_0201, 8'd5, 1'b1);
      check_unload("R2 idle ignored");
   endtask

   task automatic t_lanes_and_merge();
      do_reset();
      step(32'h2819_0A03, 8'd7, 1'b0);
      step(32'h0102_0304, 8'd200, 1'b0);
      step(32'hFF80_4001, 8'd3, 1'b1);   // last product in same cycle as done
      check_unload("R4 R5 merge");
   endtask

   task automatic t_overflow_and_clear();
      do_reset();
      for (int k = 0; k < 8; k++) step(32'hFFFF_FFFF, 8'hFF, k == 7);
      chk(expv[0] == 520200, "R10 model", expv[0], 520200);
      check_unload("R10 full range");
      step(32'h0004_0302, 8'd11, 1'b1);
      check_unload("R9 cleared");
   endtask

   initial begin
      t_reset();
      t_idle_ignore();
      t_lanes_and_merge();
      t_overflow_and_clear();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule